// File: doc/BRIEF.md
# PHY Low-Power Mode Controller

This block governs the low-power behaviour of a 10/100 Ethernet PHY. Software sets a 16-bit control word through a simple management write port and can read the word back at any time. The upper four bits hold a clock-stop request, a power-save enable and a two-bit mode selector. The block turns them into enables for the main circuitry, for the energy detector and for the internal clock tree. It also reports the resulting power state.

There are three low-power modes: full power-down, active sleep and passive sleep. In active sleep the block issues a one-cycle link-pulse request at a fixed interval, so a sleeping link partner can notice this end. In either sleep mode a link-partner-detect input wakes the block by itself. On wake the block clears the power-save enable in the register, so a later read shows that it is back at full power. The clock-stop request takes effect only in full power-down. The management port never loses power, so the word can be read and written in every mode.

Top module: `pss_top`

## Requirements
- R1: After synchronous reset the control word reads 0x0000, `core_en`, `edet_en` and `clk_en` are 1, `pwr_state` is 00 (running) and `beacon_req` is 0.
- R2: A write sets bit 15 (clock stop), bit 14 (power-save enable) and bits 13:12 (mode) of the word from `mgmt_wdata` at the next clock edge. Read data bits 11:0 are always 0, whatever was written to them.
- R3: While bit 14 is 0, every mode value gives normal operation: all three enables are 1 and `pwr_state` is 00.
- R4: With bit 14 at 1 and mode 01 (full power-down), `core_en` and `edet_en` are 0 and `pwr_state` is 01.
- R5: With bit 14 at 1 and mode 10 (active sleep) or 11 (passive sleep), `core_en` is 0, `edet_en` is 1 and `pwr_state` is 10.
- R6: `clk_en` is 0 only when bit 15 is 1 and full power-down is in effect. In every other case it is 1.
- R7: In active sleep, `beacon_req` is a one-cycle strobe that is high every `BEACON_PERIOD` cycles. The first strobe comes `BEACON_PERIOD` clock edges after the edge at which active sleep took effect, because the interval counter restarts on each entry. In every other state `beacon_req` stays 0.
- R8: When `partner_detect` is 1 at a clock edge while a sleep mode (10 or 11) is in effect, bit 14 is 0 after that edge. If a write arrives in the same cycle, the wake overrides the write for bit 14 only. The input has no effect in running or full power-down.
- R9: The control word can be read back in every power state, including full power-down with the clock stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the always-on management logic |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_wr_en | input | 1 | Write strobe for the control word |
| mgmt_wdata | input | 16 | Control word write data |
| mgmt_rdata | output | 16 | Current control word |
| partner_detect | input | 1 | Link partner seen by the energy detector |
| core_en | output | 1 | Enable for the main PHY circuitry |
| edet_en | output | 1 | Enable for the energy detector |
| clk_en | output | 1 | Enable for the internal clock tree |
| beacon_req | output | 1 | One-cycle link-pulse request |
| pwr_state | output | 2 | Power state: 00 running, 01 powered down, 10 sleeping |

## Verification
The bench builds the block with `BEACON_PERIOD` set to 6 instead of the 1.4-second default. With that value many beacon intervals fit into a short run. This makes reachable the counter wrap and the restart on re-entry, and a partner detect that lands on the same edge as a strobe or a write. Random writes over all sixteen upper-bit patterns then cover every mode under both enable values, with the clock-stop bit both set and clear.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int REG_W     = 16;
    localparam int FIELD_LSB = 12;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_PDOWN  = 2'b01,
        MODE_ASLEEP = 2'b10,
        MODE_PSLEEP = 2'b11
    } psmode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_DOWN  = 2'b01,
        ST_SLEEP = 2'b10
    } pstate_e;

    typedef struct packed {
        logic    clk_off;
        logic    ps_en;
        psmode_e mode;
    } ctrl_s;

    typedef struct packed {
        logic core;
        logic edet;
        logic clk;
    } gate_s;

    function automatic psmode_e eff_mode(ctrl_s c);
        return c.ps_en ? c.mode : MODE_RUN;
    endfunction

    function automatic logic is_sleep(psmode_e m);
        return (m == MODE_ASLEEP) || (m == MODE_PSLEEP);
    endfunction

    function automatic logic [REG_W-1:0] pack_word(ctrl_s c);
        logic [REG_W-1:0] w;
        w = '0;
        w[FIELD_LSB +: 4] = c;
        return w;
    endfunction

endpackage

// File: rtl/pss_ctrl_reg.sv
module pss_ctrl_reg
    import pss_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_s wr_val,
    input  logic  partner_detect,
    output ctrl_s ctrl
);
    logic wake;

    assign wake = ctrl.ps_en && is_sleep(ctrl.mode) && partner_detect;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{clk_off: 1'b0, ps_en: 1'b0, mode: MODE_RUN};
        end else begin
            if (wr_en) begin
                ctrl <= wr_val;
            end
            if (wake) begin
                ctrl.ps_en <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pss_gate.sv
module pss_gate
    import pss_pkg::*;
(
    input  ctrl_s   ctrl,
    output gate_s   gate,
    output pstate_e state,
    output logic    beacon_active
);
    psmode_e em;

    assign em = eff_mode(ctrl);

    always_comb begin
        gate.core     = (em == MODE_RUN);
        gate.edet     = (em != MODE_PDOWN);
        gate.clk      = !((em == MODE_PDOWN) && ctrl.clk_off);
        beacon_active = (em == MODE_ASLEEP);
        unique case (em)
            MODE_RUN:   state = ST_RUN;
            MODE_PDOWN: state = ST_DOWN;
            default:    state = ST_SLEEP;
        endcase
    end
endmodule

// File: rtl/pss_beacon.sv
module pss_beacon #(
    parameter int unsigned PERIOD = 35_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic strobe
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt     <= '0;
            pulse_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            pulse_q <= 1'b1;
        end else begin
            cnt     <= cnt + 1'b1;
            pulse_q <= 1'b0;
        end
    end

    assign strobe = pulse_q && active;
endmodule

// File: rtl/pss_top.sv
module pss_top
    import pss_pkg::*;
#(
    parameter int unsigned BEACON_PERIOD = 35_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mgmt_wr_en,
    input  logic [15:0] mgmt_wdata,
    output logic [15:0] mgmt_rdata,
    input  logic        partner_detect,
    output logic        core_en,
    output logic        edet_en,
    output logic        clk_en,
    output logic        beacon_req,
    output logic [1:0]  pwr_state
);
    ctrl_s   ctrl;
    ctrl_s   wr_val;
    gate_s   gate;
    pstate_e state;
    logic    beacon_active;
    logic    unused_wbits;

    assign wr_val       = ctrl_s'(mgmt_wdata[FIELD_LSB +: 4]);
    assign unused_wbits = ^mgmt_wdata[FIELD_LSB-1:0];

    pss_ctrl_reg u_reg (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (mgmt_wr_en),
        .wr_val         (wr_val),
        .partner_detect (partner_detect),
        .ctrl           (ctrl)
    );

    pss_gate u_gate (
        .ctrl          (ctrl),
        .gate          (gate),
        .state         (state),
        .beacon_active (beacon_active)
    );

    pss_beacon #(.PERIOD(BEACON_PERIOD)) u_beacon (
        .clk    (clk),
        .rst    (rst),
        .active (beacon_active),
        .strobe (beacon_req)
    );

    assign mgmt_rdata = pack_word(ctrl);
    assign core_en    = gate.core;
    assign edet_en    = gate.edet;
    assign clk_en     = gate.clk;
    assign pwr_state  = state;
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic        clk,
    input logic        rst,
    input logic        mgmt_wr_en,
    input logic [15:0] mgmt_wdata,
    input logic [15:0] mgmt_rdata,
    input logic        partner_detect,
    input logic        core_en,
    input logic        edet_en,
    input logic        clk_en,
    input logic        beacon_req,
    input logic [1:0]  pwr_state
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (mgmt_rdata == 16'h0000) && core_en && edet_en && clk_en && !beacon_req);

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        mgmt_wr_en |=> (mgmt_rdata[15] == $past(mgmt_wdata[15]))
                    && (mgmt_rdata[13:12] == $past(mgmt_wdata[13:12]))
                    && (mgmt_rdata[11:0] == 12'h000));

    assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        !mgmt_rdata[14] |-> core_en && edet_en && clk_en && (pwr_state == 2'b00));

    assert_pdown_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'b01) |-> !core_en && !edet_en);

    assert_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'b10) |-> !core_en && edet_en);

    assert_clkstop_R6: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> mgmt_rdata[15] && (pwr_state == 2'b01));

    assert_beacon_mode_R7: assert property (@(posedge clk) disable iff (rst)
        beacon_req |-> mgmt_rdata[14] && (mgmt_rdata[13:12] == 2'b10));

    assert_beacon_single_R7: assert property (@(posedge clk) disable iff (rst)
        beacon_req |=> !beacon_req);

    assert_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (mgmt_rdata[14] && mgmt_rdata[13] && partner_detect) |=> !mgmt_rdata[14]);
endmodule

bind pss_top pss_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .mgmt_wr_en     (mgmt_wr_en),
    .mgmt_wdata     (mgmt_wdata),
    .mgmt_rdata     (mgmt_rdata),
    .partner_detect (partner_detect),
    .core_en        (core_en),
    .edet_en        (edet_en),
    .clk_en         (clk_en),
    .beacon_req     (beacon_req),
    .pwr_state      (pwr_state)
);

// File: tb/pss_top_test.sv
module pss_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [15:0] wd  = '0;
    logic        pd  = 1'b0;
    logic [15:0] rd;
    logic        core_en, edet_en, clk_en, beacon_req;
    logic [1:0]  pwr_state;

    int errors = 0;
    int checks = 0;

    // reference state, built from the requirements
    logic       m_off, m_en;
    logic [1:0] m_mode;
    int         m_cnt;
    logic       m_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    pss_top #(.BEACON_PERIOD(PER)) uut (
        .clk(clk), .rst(rst), .mgmt_wr_en(we), .mgmt_wdata(wd), .mgmt_rdata(rd),
        .partner_detect(pd), .core_en(core_en), .edet_en(edet_en), .clk_en(clk_en),
        .beacon_req(beacon_req), .pwr_state(pwr_state)
    );

    function automatic logic [1:0] eff(logic e, logic [1:0] m);
        return e ? m : 2'b00;
    endfunction

    function automatic logic [1:0] exp_state(logic e, logic [1:0] m);
        logic [1:0] x;
        x = eff(e, m);
        return (x == 2'b00) ? 2'b00 : (x == 2'b01) ? 2'b01 : 2'b10;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_off <= 1'b0; m_en <= 1'b0; m_mode <= 2'b00; m_cnt <= 0; m_pulse <= 1'b0;
        end else begin
            automatic logic wake = m_en && m_mode[1] && pd;
            automatic logic act  = (eff(m_en, m_mode) == 2'b10);
            if (we) begin
                m_off <= wd[15]; m_en <= wd[14]; m_mode <= wd[13:12];
            end
            if (wake) m_en <= 1'b0;
            if (!act) begin
                m_cnt <= 0; m_pulse <= 1'b0;
            end else if (m_cnt == PER-1) begin
                m_cnt <= 0; m_pulse <= 1'b1;
            end else begin
                m_cnt <= m_cnt + 1; m_pulse <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_all();
        logic [1:0] x;
        x = eff(m_en, m_mode);
        chk("R2/R9 rdata", int'(rd), int'({m_off, m_en, m_mode, 12'h000}));
        chk("R3/R4/R5 core_en", int'(core_en), int'(x == 2'b00));
        chk("R4/R5 edet_en", int'(edet_en), int'(x != 2'b01));
        chk("R6 clk_en", int'(clk_en), int'(!(x == 2'b01 && m_off)));
        chk("R3/R4/R5 pwr_state", int'(pwr_state), int'(exp_state(m_en, m_mode)));
        chk("R7 beacon_req", int'(beacon_req), int'(m_pulse && x == 2'b10));
    endtask

    // drive at the falling edge, then sample just before the next one
    task automatic step(input logic w, input logic [15:0] d, input logic p);
        @(negedge clk);
        we = w; wd = d; pd = p;
        @(posedge clk);
        #1;
        we = 1'b0; pd = 1'b0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 rdata", int'(rd), 0);
        chk("R1 enables", int'({core_en, edet_en, clk_en}), 7);
        chk("R1 state", int'(pwr_state), 0);
        chk("R1 beacon", int'(beacon_req), 0);

        // R2: low bits ignored
        step(1'b1, 16'h0FFF, 1'b0);
        chk("R2 low bits", int'(rd[11:0]), 0);
        // R3: mode set without enable
        step(1'b1, 16'hB000, 1'b0);
        chk("R3 disabled", int'(pwr_state), 0);
        // R6: power-down with clock stop
        step(1'b1, 16'hD000, 1'b0);
        chk("R6 clk stopped", int'(clk_en), 0);
        chk("R4 pdown state", int'(pwr_state), 1);
        // R8: partner detect ignored in power-down
        step(1'b0, 16'h0000, 1'b1);
        chk("R8 no wake in pdown", int'(rd[14]), 1);
        // R6: clock-stop ignored in passive sleep
        step(1'b1, 16'hF000, 1'b0);
        chk("R6 clk in sleep", int'(clk_en), 1);
        chk("R5 sleep state", int'(pwr_state), 2);

        // R7: beacon timing from entry into active sleep
        step(1'b1, 16'h6000, 1'b0);
        seen = 0;
        for (int i = 1; i <= 3*PER; i++) begin
            step(1'b0, 16'h0000, 1'b0);
            if (beacon_req) begin
                seen++;
                chk("R7 beacon cycle", i % PER, 0);
            end
        end
        chk("R7 beacon count", seen, 3);

        // R8: wake beats a write in the same cycle
        step(1'b1, 16'h6000, 1'b1);
        chk("R8 wake over write", int'(rd[14]), 0);
        chk("R8 awake state", int'(pwr_state), 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            automatic logic [15:0] d = 16'($urandom());
            automatic logic w = ($urandom_range(0, 9) < 2);
            automatic logic p = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 1) == 0) d[14] = 1'b1;
            step(w, d, p);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule